// File: doc/BRIEF.md
# Page Write Cache with Deferred Commit

This block sits between a serial-bus slave front end and a nonvolatile array model. It buffers up to 64 bytes of write data in eight 8-byte lines. It does not touch the array until the transfer is closed. The front end first loads a 13-bit start address. It then streams data bytes in over a valid/ready byte port. Each accepted byte lands at the current pointer position. Only the low six address bits advance, so a transfer can cross page boundaries inside one 64-byte window while the upper seven bits stay fixed.

A stop strobe closes the transfer and starts the commit. Every line that received at least one byte is written to the array as one 8-byte page, with a byte-enable mask. Bytes that were never written keep their old array contents. After each accepted page, the block waits a fixed, parameterised number of cycles before it offers the next page. While the commit runs, the busy output is high. The front end uses busy to withhold acknowledges, and the cache refuses new bytes, new start loads and aborts. An abort strobe throws away everything captured and starts no commit.

The byte port follows valid/ready rules. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while busy and in any cycle that carries a start, stop or abort strobe, so the source must hold the byte until it is taken. The page port is also valid/ready. Once `pg_valid` rises, the page address, data and mask stay frozen until a cycle with `pg_ready` high, and the array may stall for any number of cycles.

Top module: `page_write_cache`

## Requirements
- R1: A start load (`start_ld` high while not busy) sets the page-base bits to `start_addr[12:6]` and the pointer to `start_addr[5:0]`, and empties the cache. Each accepted byte is stored at array address {base, pointer}.
- R2: After each accepted byte only the 6-bit pointer increments. Stepping past byte 7 of a line moves to byte 0 of the next line, and line 7 is followed by line 0. The base bits, which are `pg_addr[9:3]`, stay constant for the whole commit.
- R3: When more than 64 bytes arrive, the pointer wraps modulo 64, and later bytes overwrite the bytes captured earlier at the same position. Only the last value written to each position reaches the array.
- R4: The array sees no page write (`pg_valid` stays low) until a stop starts a commit. `pg_valid` is never high while busy is low.
- R5: A commit issues exactly one page write per used line. Lines go in ascending order modulo 8, beginning with the line of the start address. `pg_addr` = {base, line}. `pg_mask` bit b is set exactly for the captured bytes at position b of that line, and `pg_data[8b+7:8b]` carries that byte.
- R6: `in_ready` is high when idle with no strobe present, and low while busy. Bytes offered while busy are not taken.
- R7: While `pg_valid` is high and `pg_ready` is low, `pg_valid`, `pg_addr`, `pg_data` and `pg_mask` hold steady. A stall lengthens the busy period by exactly the number of stalled cycles.
- R8: `busy` rises in the cycle after the stop and lasts N x (PAGE_CYCLES + 1) cycles plus any stall cycles, where N is the number of used lines.
- R9: An abort while not busy empties the cache, and busy stays low in the next cycle. Abort takes precedence over a simultaneous stop.
- R10: A stop while the cache holds no captured bytes starts no commit, and busy stays low.
- R11: While busy, a start load and an abort are ignored, and the commit completes unchanged. After the commit the cache is empty and the pointer keeps its position, so bytes sent without a new start continue from it.
- R12: After reset, `busy` and `pg_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_ld | input | 1 | Load start address, one-cycle strobe |
| start_addr | input | ADDR_W | Start byte address |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_ready | output | 1 | Byte will be taken this cycle |
| stop | input | 1 | Close transfer and commit, strobe |
| abort | input | 1 | Discard transfer, strobe |
| busy | output | 1 | Commit in progress |
| pg_valid | output | 1 | Page write offered |
| pg_ready | input | 1 | Array accepts page write |
| pg_addr | output | ADDR_W-3 | Page number {base, line} |
| pg_data | output | 64 | Page bytes, byte b at bits 8b+7:8b |
| pg_mask | output | 8 | Byte enables for the page |

## Verification
The checker watches, on every cycle, that the byte port stalls while busy, that page writes only appear during a commit, that a stalled page holds its address, data and mask, that every offered page has a non-empty mask, that the base bits of the page address stay fixed through a commit, and that an idle abort never starts one. The bench scenarios are needed to show the actual array contents after read-modify-write, the ascending line order with wrap to line 0, overwrite after 64 bytes, the exact busy length as a function of used lines and stalls, and the continuation of the pointer after an ignored start load.

// File: rtl/wcache_pkg.sv
package wcache_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/wc_ptr.sv
// Address pointer: fixed base bits plus a wrapping in-window offset.
module wc_ptr #(
  parameter int ADDR_W = 13,
  parameter int OFS_W  = 6,
  parameter int LINE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [ADDR_W-1:0]       load_addr,
  input  logic                    step,
  output logic [ADDR_W-OFS_W-1:0] hi,
  output logic [OFS_W-1:0]        ofs,
  output logic [LINE_W-1:0]       first_line
);
  localparam int BYTE_W = OFS_W - LINE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi         <= '0;
      ofs        <= '0;
      first_line <= '0;
    end else if (load) begin
      hi         <= load_addr[ADDR_W-1:OFS_W];
      ofs        <= load_addr[OFS_W-1:0];
      first_line <= load_addr[OFS_W-1:BYTE_W];
    end else if (step) begin
      ofs <= ofs + OFS_W'(1);
    end
  end
endmodule

// File: rtl/wc_store.sv
// Line storage with per-byte valid flags and per-line used flags.
module wc_store #(
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 8,
  localparam int BYTE_W    = $clog2(LINE_BYTES),
  localparam int LINE_W    = $clog2(LINES),
  localparam int SLOTS     = LINES * LINE_BYTES,
  localparam int OFS_W     = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [OFS_W-1:0]        wr_ofs,
  input  logic [7:0]              wr_data,
  input  logic [LINE_W-1:0]       rd_line,
  output logic [LINE_BYTES*8-1:0] rd_data,
  output logic [LINE_BYTES-1:0]   rd_mask,
  output logic [LINES-1:0]        line_used
);
  logic [7:0]       slot [SLOTS];
  logic [SLOTS-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_ofs] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     vld <= '0;
    else if (clr)   vld <= '0;
    else if (wr_en) vld[wr_ofs] <= 1'b1;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_used
    assign line_used[l] = |vld[l*LINE_BYTES +: LINE_BYTES];
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_rd
    assign rd_data[b*8 +: 8] = slot[{rd_line, BYTE_W'(b)}];
    assign rd_mask[b]        = vld[{rd_line, BYTE_W'(b)}];
  end
endmodule

// File: rtl/wc_seq.sv
// Commit sequencer: walks used lines from the start line, one page per
// handshake, then a self-timed wait per page.
module wc_seq
  import wcache_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int PAGE_CYCLES = 20,
  localparam int LINE_W     = $clog2(LINES),
  localparam int TMR_W      = $clog2(PAGE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LINES-1:0]  line_used,
  input  logic [LINE_W-1:0] first_line,
  input  logic              pg_ready,
  output logic              busy,
  output logic              pg_valid,
  output logic [LINE_W-1:0] cur_line,
  output logic              done
);
  sq_state_t         st;
  logic [LINE_W-1:0] off_q;
  logic [TMR_W-1:0]  tmr;
  logic [LINE_W:0]   first_hit;
  logic [LINE_W:0]   next_hit;
  logic              last_tick;

  // Smallest offset >= from whose line (base + offset, modulo LINES) is used.
  function automatic logic [LINE_W:0] seek(input logic [LINES-1:0]  used,
                                           input logic [LINE_W-1:0] base,
                                           input logic [LINE_W:0]   from);
    logic [LINE_W:0]   r;
    logic [LINE_W-1:0] idx;
    r = '0;
    for (int o = LINES - 1; o >= 0; o--) begin
      idx = base + LINE_W'(o);
      if (((LINE_W+1)'(o) >= from) && used[idx]) r = {1'b1, LINE_W'(o)};
    end
    return r;
  endfunction

  always_comb begin
    first_hit = seek(line_used, first_line, '0);
    next_hit  = seek(line_used, first_line, {1'b0, off_q} + (LINE_W+1)'(1));
    last_tick = (st == SQ_WAIT) && (tmr == TMR_W'(PAGE_CYCLES - 1));
  end

  assign done     = last_tick && !next_hit[LINE_W];
  assign busy     = (st != SQ_IDLE);
  assign pg_valid = (st == SQ_ISSUE);
  assign cur_line = first_line + off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      off_q <= '0;
      tmr   <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (go && first_hit[LINE_W]) begin
            off_q <= first_hit[LINE_W-1:0];
            st    <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (pg_ready) begin
            tmr <= '0;
            st  <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (last_tick) begin
            if (next_hit[LINE_W]) begin
              off_q <= next_hit[LINE_W-1:0];
              st    <= SQ_ISSUE;
            end else begin
              st <= SQ_IDLE;
            end
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_write_cache.sv
module page_write_cache #(
  parameter int ADDR_W      = 13,
  parameter int LINE_BYTES  = 8,
  parameter int LINES       = 8,
  parameter int PAGE_CYCLES = 20,
  localparam int BYTE_W     = $clog2(LINE_BYTES),
  localparam int LINE_W     = $clog2(LINES),
  localparam int OFS_W      = BYTE_W + LINE_W,
  localparam int HI_W       = ADDR_W - OFS_W,
  localparam int PAGE_W     = ADDR_W - BYTE_W,
  localparam int DATA_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ld,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              stop,
  input  logic              abort,
  output logic              busy,
  output logic              pg_valid,
  input  logic              pg_ready,
  output logic [PAGE_W-1:0] pg_addr,
  output logic [DATA_W-1:0] pg_data,
  output logic [LINE_BYTES-1:0] pg_mask
);
  logic [HI_W-1:0]   hi;
  logic [OFS_W-1:0]  ofs;
  logic [LINE_W-1:0] first_line;
  logic [LINE_W-1:0] cur_line;
  logic [LINES-1:0]  line_used;
  logic              take, load, go, clr, done;

  assign in_ready = ~busy & ~start_ld & ~stop & ~abort;
  assign take     = in_valid & in_ready;
  assign load     = start_ld & ~busy;
  assign go       = stop & ~abort & ~busy;
  assign clr      = load | (abort & ~busy) | done;
  assign pg_addr  = {hi, cur_line};

  wc_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_W(LINE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(start_addr),
    .step(take), .hi(hi), .ofs(ofs), .first_line(first_line)
  );

  wc_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(take), .wr_ofs(ofs),
    .wr_data(in_data), .rd_line(cur_line), .rd_data(pg_data),
    .rd_mask(pg_mask), .line_used(line_used)
  );

  wc_seq #(.LINES(LINES), .PAGE_CYCLES(PAGE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .line_used(line_used),
    .first_line(first_line), .pg_ready(pg_ready), .busy(busy),
    .pg_valid(pg_valid), .cur_line(cur_line), .done(done)
  );
endmodule

// File: rtl/wcache_chk.sv
module wcache_chk #(
  parameter int PAGE_W = 10,
  parameter int LINE_W = 3,
  parameter int DATA_W = 64,
  parameter int MASK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              in_ready,
  input logic              abort,
  input logic              pg_valid,
  input logic              pg_ready,
  input logic [PAGE_W-1:0] pg_addr,
  input logic [DATA_W-1:0] pg_data,
  input logic [MASK_W-1:0] pg_mask
);
  AST_BUSY_STALLS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);                                              // R6
  AST_PAGE_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pg_valid |-> busy);                                               // R4
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && !pg_ready) |=> (pg_valid && $stable(pg_addr) &&
                                 $stable(pg_data) && $stable(pg_mask))); // R7
  AST_MASK_USED: assert property (@(posedge clk) disable iff (!rst_n)
    pg_valid |-> (pg_mask != '0));                                    // R5
  AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && abort) |=> !busy);                                      // R9
  AST_BASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pg_addr[PAGE_W-1:LINE_W]));     // R2
endmodule

bind page_write_cache wcache_chk #(
  .PAGE_W(PAGE_W), .LINE_W(LINE_W), .DATA_W(DATA_W), .MASK_W(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .in_ready(in_ready),
  .abort(abort), .pg_valid(pg_valid), .pg_ready(pg_ready),
  .pg_addr(pg_addr), .pg_data(pg_data), .pg_mask(pg_mask)
);

// File: tb/sim_page_write_cache.sv
module sim_page_write_cache;
  localparam int PC = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_ld, in_valid, stop, abort;
  logic [12:0] start_addr;
  logic [7:0]  in_data;
  logic        in_ready, busy, pg_valid, pg_ready;
  logic [9:0]  pg_addr;
  logic [63:0] pg_data;
  logic [7:0]  pg_mask;

  always #10 clk = ~clk;

  page_write_cache #(.PAGE_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_ld(start_ld), .start_addr(start_addr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .stop(stop), .abort(abort), .busy(busy), .pg_valid(pg_valid),
    .pg_ready(pg_ready), .pg_addr(pg_addr), .pg_data(pg_data), .pg_mask(pg_mask)
  );

  // array model driven by the page port, and the expected array
  logic [7:0] arr     [8192];
  logic [7:0] exp_mem [8192];
  // cache model
  logic [7:0] c_d [64];
  bit         c_v [64];
  int m_hi, m_lo, m_first;
  int exp_pg [8];
  int exp_n;
  int pg_log [16];
  int pg_n;
  int busy_cnt;
  int stall_ctr;
  int nchk, nbad;

  assign pg_ready = (stall_ctr == 0);

  always @(posedge clk) begin
    if (pg_valid && stall_ctr > 0) stall_ctr <= stall_ctr - 1;
  end

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (pg_valid && pg_ready) begin
      for (int b = 0; b < 8; b++)
        if (pg_mask[b]) arr[int'(pg_addr) * 8 + b] = pg_data[b*8 +: 8];
      if (pg_n < 16) pg_log[pg_n] = int'(pg_addr);
      pg_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  task automatic m_clear();
    for (int i = 0; i < 64; i++) c_v[i] = 1'b0;
  endtask

  task automatic m_commit();
    exp_n = 0;
    for (int k = 0; k < 8; k++) begin
      int  ln;
      bit  used;
      ln = (m_first + k) % 8;
      used = 1'b0;
      for (int b = 0; b < 8; b++) if (c_v[ln*8+b]) used = 1'b1;
      if (used) begin
        exp_pg[exp_n] = m_hi * 8 + ln;
        exp_n++;
        for (int b = 0; b < 8; b++)
          if (c_v[ln*8+b]) exp_mem[m_hi*64 + ln*8 + b] = c_d[ln*8+b];
      end
    end
    m_clear();
  endtask

  task automatic load(input int addr);
    start_ld = 1'b1;
    start_addr = 13'(addr);
    @(negedge clk);
    start_ld = 1'b0;
    m_hi = addr / 64;
    m_lo = addr % 64;
    m_first = m_lo / 8;
    m_clear();
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      in_valid = 1'b1;
      in_data = d;
      @(negedge clk);
      c_d[m_lo] = d;
      c_v[m_lo] = 1'b1;
      m_lo = (m_lo + 1) % 64;
    end
    in_valid = 1'b0;
  endtask

  // mode 0: stop, mode 1: abort
  task automatic close(input int mode, input int stall, input bit poke, input string tag);
    int exp_cycles;
    int bad_at;
    bit ord_ok;
    chk(pg_n == 0, "R4", "page write before STOP", pg_n, 0);
    busy_cnt = 0;
    pg_n = 0;
    stall_ctr <= stall;
    if (mode == 0) begin
      stop = 1'b1;
      m_commit();
    end else begin
      abort = 1'b1;
      m_clear();
      exp_n = 0;
    end
    @(negedge clk);
    stop = 1'b0;
    abort = 1'b0;
    if (poke && busy) begin
      start_ld = 1'b1;
      start_addr = 13'h1555;
      abort = 1'b1;
      in_valid = 1'b1;
      in_data = 8'hEE;
      chk(in_ready == 1'b0, "R11", "in_ready while busy", in_ready, 0);
      @(negedge clk);
      start_ld = 1'b0;
      abort = 1'b0;
      in_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    exp_cycles = exp_n * (PC + 1) + ((exp_n > 0) ? stall : 0);
    chk(busy_cnt == exp_cycles,
        (exp_n == 0) ? ((mode == 1) ? "R9" : "R10") : ((stall > 0) ? "R7" : "R8"),
        "busy cycles", busy_cnt, exp_cycles);
    chk(pg_n == exp_n, "R5", "page write count", pg_n, exp_n);
    ord_ok = 1'b1;
    for (int i = 0; i < exp_n && i < pg_n; i++)
      if (pg_log[i] != exp_pg[i]) ord_ok = 1'b0;
    chk(ord_ok, "R5", "page order", (pg_n > 0) ? pg_log[0] : -1,
        (exp_n > 0) ? exp_pg[0] : -1);
    bad_at = -1;
    for (int a = 0; a < 8192; a++)
      if (bad_at < 0 && arr[a] !== exp_mem[a]) bad_at = a;
    chk(bad_at < 0, tag, $sformatf("array byte at %0d", bad_at),
        (bad_at < 0) ? 0 : arr[bad_at], (bad_at < 0) ? 0 : exp_mem[bad_at]);
    stall_ctr <= 0;
    pg_n = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL R8 watchdog expired act=%0d exp=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    nchk = 0; nbad = 0; pg_n = 0; busy_cnt = 0; stall_ctr = 0;
    rst_n = 1'b0; start_ld = 1'b0; start_addr = '0; in_valid = 1'b0;
    in_data = '0; stop = 1'b0; abort = 1'b0;
    for (int a = 0; a < 8192; a++) begin
      arr[a] = 8'($urandom);
      exp_mem[a] = arr[a];
    end
    m_hi = 0; m_lo = 0; m_first = 0;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R12", "busy after reset", busy, 0);
    chk(pg_valid == 1'b0, "R12", "pg_valid after reset", pg_valid, 0);
    chk(in_ready == 1'b1, "R6", "in_ready idle", in_ready, 1);

    // single byte, rest of page kept
    load(13'h0123); send(1); close(0, 0, 1'b0, "R1");
    // one aligned full page
    load(13'h0A40); send(8); close(0, 0, 1'b0, "R1");
    // start near window end: line 7 then line 0, base fixed
    load(13'h1FFD); send(10); close(0, 0, 1'b0, "R2");
    // exactly 64 bytes from line 1: all lines, order 1..7,0
    load(13'h0208); send(64); close(0, 0, 1'b0, "R5");
    // overflow: 75 bytes overwrite the first 11
    load(13'h0100); send(75); close(0, 0, 1'b0, "R3");
    // abort discards, then stop with empty cache
    load(13'h0333); send(12); close(1, 0, 1'b0, "R9");
    close(0, 0, 1'b0, "R10");
    // stall on the page port
    load(13'h0C12); send(20); close(0, 4, 1'b0, "R7");
    // start/abort/byte while busy are ignored, then continue without start
    load(13'h0E3C); send(9); close(0, 0, 1'b1, "R11");
    send(5); close(0, 0, 1'b0, "R11");

    // constrained random transfers
    for (int t = 0; t < 30; t++) begin
      int addr, n, mode, st;
      addr = int'($urandom % 8192);
      n    = int'($urandom % 90);
      mode = ($urandom % 6 == 0) ? 1 : 0;
      st   = int'($urandom % 3);
      load(addr);
      send(n);
      close(mode, st, 1'b0, (n > 64) ? "R3" : "R1");
    end

    summary();
    $finish;
  end
endmodule